// File: doc/BRIEF.md
# Dual-Slope PWM Timer with Selectable Prescaler

This block is a 16-bit counter that runs in phase-and-frequency-correct fashion. It climbs from zero to a programmable ceiling (TOP), then falls back to zero, and repeats. A full cycle therefore lasts twice TOP counting steps. A selectable prescaler paces the counting steps. The prescaler can be halted and resumed without losing the count, and its phase can be cleared on its own.

Two compare channels, A and B, turn the counter into symmetric PWM waveforms. Each channel drives its pin only while its output enable is set. The ceiling and both compare values are shadowed, and the running copies take them up only when the counter leaves zero, so a period is never cut short. A bottom flag records that the counter has been at zero. It is cleared by writing 1 to it, and its interrupt line is gated by an enable bit.

Software writes a 3-bit register address with 16-bit data. The live count is always visible on an output.

Top module: `dspwm_timer`

## Requirements
- R1: After reset, the count output is 0, the bottom flag and interrupt are 0, and both pin enables and both pins are 0.
- R2: With TOP ≥ 1, the count steps 0,1,…,TOP,TOP−1,…,1 and then returns to 0. The period is 2·TOP counting steps. TOP is written at address 0.
- R3: The clock select field is bits [2:0] of the control register at address 3. Value 0 stops counting. Values 1, 2, 3, 4 and 5 give one counting step every 1, 8, 64, 256 and 1024 clocks. Values 6 and 7 also stop counting.
- R4: While clock select is 0, the count holds its value. Writing a nonzero select resumes from that value, one step away from it, without clearing it.
- R5: Any write to address 6 restarts the prescaler phase. With select 2, the next counting step lands exactly 8 clocks after the clock edge that takes the write.
- R6: The compare values are at address 1 (A) and address 2 (B). The output is non-inverting: it falls when the count meets the compare value on the way up and rises when it meets it on the way down. For 0 < CMP < TOP, the pin is high for 2·CMP of the 2·TOP steps in each period.
- R7: A compare value of 0 holds the pin low. A compare value ≥ TOP holds it high.
- R8: Writes to TOP and the compare registers land in shadow copies. They take effect only when the counter next leaves zero.
- R9: A write to address 4 loads the count directly, and it shows on the count output after that edge. The bottom flag is set in every clock where the count is zero and clock select is 1 to 5. It stays clear while stopped at zero.
- R10: Writing address 5 with data bit 0 set clears the bottom flag, unless the flag is being set in the same clock. Writing 0 in that bit has no effect.
- R11: The interrupt output equals the bottom flag ANDed with control bit 5.
- R12: Control bit 3 enables pin A and control bit 4 enables pin B. Each enable appears on its enable output. A disabled pin is driven 0 whatever the compare state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 16 | Register write data |
| cnt_o | output | 16 | Live counter value |
| ovf_flag_o | output | 1 | Bottom flag |
| irq_o | output | 1 | Gated bottom interrupt |
| pwm_a_o | output | 1 | Channel A pin level |
| pwm_a_en_o | output | 1 | Channel A pin drive enable |
| pwm_b_o | output | 1 | Channel B pin level |
| pwm_b_en_o | output | 1 | Channel B pin drive enable |

## Verification
The bench builds the block with its default widths: a 16-bit counter and a 10-bit prescaler phase. The wide prescaler makes the ÷1024 setting reachable. Using small ceilings (1 to 10) keeps every period at or under 4096 clocks, so all five divider settings, the degenerate TOP=1 waveform and both compare extremes (0 and ≥ TOP) are measured over whole periods. The stop, resume, prescaler-restart and shadow-register cases are driven with ceilings of 10 and 20, where a stray step or an early load shows up directly in the count.

// File: rtl/dspwm_pkg.sv
package dspwm_pkg;

    // Register addresses of the write port
    typedef enum logic [2:0] {
        ADR_TOP    = 3'd0,
        ADR_CMP_A  = 3'd1,
        ADR_CMP_B  = 3'd2,
        ADR_CTRL   = 3'd3,
        ADR_COUNT  = 3'd4,
        ADR_STATUS = 3'd5,
        ADR_PRST   = 3'd6
    } reg_addr_e;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_e;

    // Control register, LSB first: clk_sel[2:0], oe_a[3], oe_b[4], ovf_ie[5]
    typedef struct packed {
        logic       ovf_ie;
        logic       oe_b;
        logic       oe_a;
        logic [2:0] clk_sel;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    // log2 of the division ratio for a clock select code
    function automatic int div_log2(input logic [2:0] sel);
        case (sel)
            3'd2:    return 3;
            3'd3:    return 6;
            3'd4:    return 8;
            3'd5:    return 10;
            default: return 0;
        endcase
    endfunction

    function automatic logic sel_running(input logic [2:0] sel);
        return (sel != 3'd0) && (sel <= 3'd5);
    endfunction

endpackage

// File: rtl/dspwm_prescaler.sv
module dspwm_prescaler
    import dspwm_pkg::*;
#(
    parameter int PRE_W = 10
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic [2:0] clk_sel_i,
    input  logic       clr_i,
    output logic       tick_o
);

    typedef struct packed {
        logic [PRE_W-1:0] phase;
    } pre_state_t;

    pre_state_t       pre_q, pre_d;
    logic [PRE_W-1:0] mask;
    int               shift;

    always_comb begin
        pre_d = pre_q;
        shift = div_log2(clk_sel_i);
        mask  = '0;
        for (int i = 0; i < PRE_W; i++) begin
            if (i < shift) mask[i] = 1'b1;
        end
        // free-running phase; a restart request zeroes it
        pre_d.phase = clr_i ? '0 : pre_q.phase + 1'b1;
        // a step fires when all phase bits below the ratio are set
        tick_o = sel_running(clk_sel_i) && !clr_i &&
                 ((pre_q.phase & mask) == mask);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pre_q <= '0;
        else         pre_q <= pre_d;
    end

endmodule

// File: rtl/dspwm_counter.sv
module dspwm_counter
    import dspwm_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int NCH   = 2
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic                       tick_i,
    input  logic                       load_i,
    input  logic [CNT_W-1:0]           load_val_i,
    input  logic [CNT_W-1:0]           top_buf_i,
    input  logic [NCH-1:0][CNT_W-1:0]  cmp_buf_i,
    output logic [CNT_W-1:0]           cnt_o,
    output dir_e                       dir_o,
    output logic [CNT_W-1:0]           top_act_o,
    output logic [NCH-1:0][CNT_W-1:0]  cmp_act_o
);

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [CNT_W-1:0]          cnt;
        dir_e                      dir;
        logic [CNT_W-1:0]          top_act;
        logic [NCH-1:0][CNT_W-1:0] cmp_act;
    } cnt_state_t;

    cnt_state_t       cnt_q, cnt_d;
    logic             leave_bottom;
    logic [CNT_W-1:0] top_use;

    always_comb begin
        cnt_d = cnt_q;
        // shadow copies are taken up on the step that leaves zero
        leave_bottom = tick_i && (cnt_q.cnt == '0) && !load_i;
        top_use      = leave_bottom ? top_buf_i : cnt_q.top_act;
        if (leave_bottom) begin
            cnt_d.top_act = top_buf_i;
            cnt_d.cmp_act = cmp_buf_i;
        end
        if (load_i) begin
            cnt_d.cnt = load_val_i;
            cnt_d.dir = DIR_UP;
        end else if (tick_i) begin
            if (cnt_q.dir == DIR_UP && cnt_q.cnt < top_use) begin
                cnt_d.cnt = cnt_q.cnt + 1'b1;
            end else if (cnt_q.cnt == '0) begin
                // ceiling of zero, or a loaded zero while falling
                cnt_d.cnt = '0;
                cnt_d.dir = DIR_UP;
            end else begin
                cnt_d.cnt = cnt_q.cnt - 1'b1;
                cnt_d.dir = (cnt_q.cnt == ONE) ? DIR_UP : DIR_DOWN;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q.cnt     <= '0;
            cnt_q.dir     <= DIR_UP;
            cnt_q.top_act <= '1;
            cnt_q.cmp_act <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_o     = cnt_q.cnt;
    assign dir_o     = cnt_q.dir;
    assign top_act_o = cnt_q.top_act;
    assign cmp_act_o = cnt_q.cmp_act;

endmodule

// File: rtl/dspwm_channel.sv
module dspwm_channel
    import dspwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [CNT_W-1:0] cnt_i,
    input  dir_e             dir_i,
    input  logic [CNT_W-1:0] top_i,
    input  logic [CNT_W-1:0] cmp_i,
    input  logic             oe_i,
    output logic             pin_o,
    output logic             pin_en_o
);

    typedef struct packed {
        logic level;
    } ch_state_t;

    ch_state_t ch_q, ch_d;

    always_comb begin
        ch_d = ch_q;
        if (cmp_i == '0) begin
            ch_d.level = 1'b0;
        end else if (cmp_i >= top_i) begin
            ch_d.level = 1'b1;
        end else if (dir_i == DIR_UP) begin
            // falls on the rising match
            ch_d.level = (cnt_i < cmp_i);
        end else begin
            // rises on the falling match
            ch_d.level = (cnt_i <= cmp_i);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ch_q <= '0;
        else         ch_q <= ch_d;
    end

    assign pin_o    = oe_i & ch_q.level;
    assign pin_en_o = oe_i;

endmodule

// File: rtl/dspwm_timer.sv
module dspwm_timer
    import dspwm_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 3,
    parameter int PRE_W  = 10
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [CNT_W-1:0]  wr_data_i,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              ovf_flag_o,
    output logic              irq_o,
    output logic              pwm_a_o,
    output logic              pwm_a_en_o,
    output logic              pwm_b_o,
    output logic              pwm_b_en_o
);

    localparam int NCH = 2;

    typedef struct packed {
        ctrl_t                     ctrl;
        logic [CNT_W-1:0]          top_buf;
        logic [NCH-1:0][CNT_W-1:0] cmp_buf;
        logic                      ovf;
    } reg_state_t;

    reg_state_t                reg_q, reg_d;
    logic                      cnt_wr;
    logic                      presc_clr;
    logic                      tick;
    logic                      running;
    logic [2:0]                clk_sel;
    logic [CNT_W-1:0]          cnt;
    dir_e                      dir;
    logic [CNT_W-1:0]          top_act;
    logic [NCH-1:0][CNT_W-1:0] cmp_act;
    logic [NCH-1:0]            oe;
    logic [NCH-1:0]            pin;
    logic [NCH-1:0]            pin_en;

    assign clk_sel = reg_q.ctrl.clk_sel;
    assign running = sel_running(clk_sel);

    always_comb begin
        reg_d     = reg_q;
        cnt_wr    = 1'b0;
        presc_clr = 1'b0;
        if (wr_en_i) begin
            case (wr_addr_i)
                ADR_TOP:    reg_d.top_buf    = wr_data_i;
                ADR_CMP_A:  reg_d.cmp_buf[0] = wr_data_i;
                ADR_CMP_B:  reg_d.cmp_buf[1] = wr_data_i;
                ADR_CTRL:   reg_d.ctrl       = ctrl_t'(wr_data_i[CTRL_W-1:0]);
                ADR_COUNT:  cnt_wr           = 1'b1;
                ADR_STATUS: if (wr_data_i[0]) reg_d.ovf = 1'b0;
                ADR_PRST:   presc_clr        = 1'b1;
                default:    ;
            endcase
        end
        // setting the flag takes priority over clearing it
        if (running && cnt == '0) reg_d.ovf = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            reg_q.ctrl    <= '0;
            reg_q.top_buf <= '1;
            reg_q.cmp_buf <= '0;
            reg_q.ovf     <= 1'b0;
        end else begin
            reg_q <= reg_d;
        end
    end

    dspwm_prescaler #(
        .PRE_W (PRE_W)
    ) u_presc (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .clk_sel_i (clk_sel),
        .clr_i     (presc_clr),
        .tick_o    (tick)
    );

    dspwm_counter #(
        .CNT_W (CNT_W),
        .NCH   (NCH)
    ) u_cnt (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .tick_i     (tick),
        .load_i     (cnt_wr),
        .load_val_i (wr_data_i),
        .top_buf_i  (reg_q.top_buf),
        .cmp_buf_i  (reg_q.cmp_buf),
        .cnt_o      (cnt),
        .dir_o      (dir),
        .top_act_o  (top_act),
        .cmp_act_o  (cmp_act)
    );

    assign oe = {reg_q.ctrl.oe_b, reg_q.ctrl.oe_a};

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        dspwm_channel #(
            .CNT_W (CNT_W)
        ) u_ch (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .cnt_i    (cnt),
            .dir_i    (dir),
            .top_i    (top_act),
            .cmp_i    (cmp_act[ch]),
            .oe_i     (oe[ch]),
            .pin_o    (pin[ch]),
            .pin_en_o (pin_en[ch])
        );
    end

    assign cnt_o      = cnt;
    assign ovf_flag_o = reg_q.ovf;
    assign irq_o      = reg_q.ovf & reg_q.ctrl.ovf_ie;
    assign pwm_a_o    = pin[0];
    assign pwm_a_en_o = pin_en[0];
    assign pwm_b_o    = pin[1];
    assign pwm_b_en_o = pin_en[1];

endmodule

// File: rtl/dspwm_timer_chk.sv
module dspwm_timer_chk
    import dspwm_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 3
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              wr_en_i,
    input logic [ADDR_W-1:0] wr_addr_i,
    input logic [CNT_W-1:0]  wr_data_i,
    input logic [2:0]        clk_sel_i,
    input logic              run_i,
    input logic              tick_i,
    input logic [CNT_W-1:0]  cnt_o,
    input logic [CNT_W-1:0]  cmp_a_act_i,
    input logic              ovf_flag_o,
    input logic              irq_o,
    input logic              pwm_a_o,
    input logic              pwm_a_en_o
);

    logic cnt_wr;
    assign cnt_wr = wr_en_i && (wr_addr_i == ADR_COUNT);

    // R4
    stopped_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clk_sel_i == 3'd0 && !cnt_wr) |=> $stable(cnt_o));

    // R2
    single_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && !cnt_wr) |=> (cnt_o == $past(cnt_o) + 1'b1 ||
                                 cnt_o == $past(cnt_o) - 1'b1 ||
                                 cnt_o == '0));

    // R9
    bottom_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && cnt_o == '0) |=> ovf_flag_o);

    // R10
    flag_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_addr_i == ADR_STATUS && wr_data_i[0] &&
         !(run_i && cnt_o == '0)) |=> !ovf_flag_o);

    // R11
    irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> ovf_flag_o);

    // R5
    presc_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_addr_i == ADR_PRST && clk_sel_i >= 3'd2 &&
         clk_sel_i <= 3'd5) |=> !tick_i);

    // R7
    cmp_zero_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmp_a_act_i == '0 && pwm_a_en_o) |=> !pwm_a_o);

endmodule

bind dspwm_timer dspwm_timer_chk #(
    .CNT_W  (CNT_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_addr_i   (wr_addr_i),
    .wr_data_i   (wr_data_i),
    .clk_sel_i   (clk_sel),
    .run_i       (running),
    .tick_i      (tick),
    .cnt_o       (cnt_o),
    .cmp_a_act_i (cmp_act[0]),
    .ovf_flag_o  (ovf_flag_o),
    .irq_o       (irq_o),
    .pwm_a_o     (pwm_a_o),
    .pwm_a_en_o  (pwm_a_en_o)
);

// File: tb/dspwm_timer_test.sv
module dspwm_timer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] cnt;
    logic        ovf, irq, pa, pa_en, pb, pb_en;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    dspwm_timer uut (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .wr_en_i    (wr_en),
        .wr_addr_i  (wr_addr),
        .wr_data_i  (wr_data),
        .cnt_o      (cnt),
        .ovf_flag_o (ovf),
        .irq_o      (irq),
        .pwm_a_o    (pa),
        .pwm_a_en_o (pa_en),
        .pwm_b_o    (pb),
        .pwm_b_en_o (pb_en)
    );

    typedef struct packed {
        logic [2:0]  cs;
        logic [15:0] top;
        logic [15:0] cmpa;
        logic [15:0] cmpb;
        int unsigned period;
        int unsigned high_a;
        int unsigned high_b;
    } vec_t;

    // period = 2*TOP*div, high = 2*min(CMP,TOP)*div, 0 when CMP = 0
    localparam vec_t VECS [8] = '{
        '{3'd1, 16'd10, 16'd4,  16'd7,  20,   8,    14},
        '{3'd1, 16'd10, 16'd0,  16'd10, 20,   0,    20},
        '{3'd1, 16'd10, 16'd15, 16'd1,  20,   20,   2},
        '{3'd1, 16'd1,  16'd1,  16'd0,  2,    2,    0},
        '{3'd2, 16'd6,  16'd2,  16'd5,  96,   32,   80},
        '{3'd3, 16'd3,  16'd1,  16'd2,  384,  128,  256},
        '{3'd4, 16'd2,  16'd1,  16'd3,  1024, 512,  1024},
        '{3'd5, 16'd2,  16'd1,  16'd0,  4096, 2048, 0}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int mx;
        int c0;
        int n;
        bit seen;

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check(cnt == 0, "R1 count", cnt, 0);
        check(ovf == 0 && irq == 0, "R1 flag/irq", ovf + irq, 0);
        check(pa_en == 0 && pb_en == 0, "R1 enables", pa_en + pb_en, 0);
        check(pa == 0 && pb == 0, "R1 pins", pa + pb, 0);
        rst_n = 1'b1;

        // R8 shadowed ceiling, ctrl 0x19 = cs1 + both enables
        wr(3'd0, 16'd10);
        wr(3'd1, 16'd4);
        wr(3'd2, 16'd7);
        wr(3'd3, 16'h0019);
        wr(3'd4, 16'd0);
        do @(negedge clk); while (cnt != 16'd3);
        wr(3'd0, 16'd20);
        mx = 0;
        do begin
            @(negedge clk);
            if (int'(cnt) > mx) mx = int'(cnt);
        end while (cnt != 0);
        check(mx == 10, "R8 old ceiling kept", mx, 10);
        do @(negedge clk); while (cnt == 0);
        mx = 0;
        do begin
            @(negedge clk);
            if (int'(cnt) > mx) mx = int'(cnt);
        end while (cnt != 0);
        check(mx == 20, "R8 new ceiling", mx, 20);

        // R4 stop and resume
        repeat (5) @(negedge clk);
        wr(3'd3, 16'h0018);
        c0 = int'(cnt);
        repeat (20) @(negedge clk);
        check(int'(cnt) == c0, "R4 hold while stopped", cnt, c0);
        wr(3'd3, 16'h0019);
        check(int'(cnt) == c0, "R4 no step on resume edge", cnt, c0);
        @(posedge clk);
        #1;
        check(int'(cnt) == c0 + 1 || int'(cnt) == c0 - 1, "R4 resume continues", cnt, c0 + 1);

        // R5 prescaler restart with divide by 8
        wr(3'd3, 16'h001A);
        repeat (3) @(negedge clk);
        wr(3'd6, 16'd0);
        c0 = int'(cnt);
        n = 0;
        do begin
            @(posedge clk);
            #1;
            n++;
        end while (int'(cnt) == c0 && n < 100);
        check(n == 8, "R5 full interval after restart", n, 8);

        // R9 / R10 / R11 bottom flag
        wr(3'd3, 16'h0000);
        wr(3'd4, 16'd5);
        wr(3'd5, 16'd1);
        @(negedge clk);
        check(cnt == 5, "R9 count load", cnt, 5);
        check(ovf == 0, "R10 clear", ovf, 0);
        wr(3'd4, 16'd0);
        repeat (3) @(negedge clk);
        check(ovf == 0, "R9 stopped at zero", ovf, 0);
        wr(3'd3, 16'h0001);
        @(posedge clk);
        @(negedge clk);
        check(ovf == 1, "R9 set at zero while running", ovf, 1);
        check(irq == 0, "R11 masked", irq, 0);
        wr(3'd3, 16'h0020);
        @(negedge clk);
        check(irq == 1, "R11 enabled", irq, 1);
        wr(3'd4, 16'd7);
        wr(3'd5, 16'd0);
        @(negedge clk);
        check(ovf == 1, "R10 zero write no effect", ovf, 1);
        wr(3'd5, 16'd1);
        @(negedge clk);
        check(ovf == 0 && irq == 0, "R10 clear by one", ovf + irq, 0);

        // R12 pin enables, ctrl 0x11 = cs1 + only B
        wr(3'd1, 16'd5);
        wr(3'd2, 16'd5);
        wr(3'd3, 16'h0011);
        seen = 1'b0;
        mx = 0;
        repeat (80) begin
            @(negedge clk);
            if (pb) seen = 1'b1;
            if (pa || pa_en) mx++;
        end
        check(mx == 0, "R12 A released", mx, 0);
        check(pb_en == 1 && seen, "R12 B driven", pb_en + seen, 2);
        wr(3'd3, 16'h0001);
        @(negedge clk);
        check(pb_en == 0 && pb == 0, "R12 B released", pb_en + pb, 0);

        // R2 R3 R6 R7 vector walk
        foreach (VECS[i]) begin
            bit nz;
            int per;
            int ha;
            int hb;
            wr(3'd0, VECS[i].top);
            wr(3'd1, VECS[i].cmpa);
            wr(3'd2, VECS[i].cmpb);
            wr(3'd3, {13'h0000, VECS[i].cs} | 16'h0018);
            repeat (9000) @(negedge clk);
            nz = 1'b0;
            do begin
                @(negedge clk);
                if (cnt != 0) nz = 1'b1;
            end while (!(nz && cnt == 0));
            per = 0;
            nz = 1'b0;
            do begin
                @(negedge clk);
                per++;
                if (cnt != 0) nz = 1'b1;
            end while (!(nz && cnt == 0));
            check(per == int'(VECS[i].period), "R2/R3 period", per, int'(VECS[i].period));
            ha = 0;
            hb = 0;
            repeat (VECS[i].period) begin
                @(negedge clk);
                ha += int'(pa);
                hb += int'(pb);
            end
            check(ha == int'(VECS[i].high_a), "R6/R7 high time A", ha, int'(VECS[i].high_a));
            check(hb == int'(VECS[i].high_b), "R6/R7 high time B", hb, int'(VECS[i].high_b));
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule